// File: doc/BRIEF.md
# Transceiver power-up sequencer

This block takes a multi-lane serial transceiver from power-on, or from a low-power or bypass episode, to the point where received data may be used. It counts reference-clock cycles against thresholds given in microseconds and scaled by a reference-frequency parameter (125 MHz by default). While the count runs, it moves through named phases. Each phase drives control strobes for the frequency synthesiser, the receiver's analog calibration, the receiver's data tracking, and finally the parallel data outputs together with comma detection.

One global machine holds the shared schedule. The sequence runs only when reset, PLL bypass and low-power request are all inactive. Asserting bypass or low-power parks the machine. Releasing both replays the full schedule from time zero. Each lane also has a small machine of its own, driven by a per-lane lock-to-reference control (`lockref_n`, active low). Pulling that control low idles the lane. Releasing it gives a short relock window, after which the lane's data is enabled again.

Global states and their `seq_state` codes:

| Code | State | Meaning |
|------|-------|---------|
| 0 | RESET | Reset is asserted. |
| 1 | PARK | Bypass or low-power is active. |
| 2 | BIAS | 0 to 32 µs: synthesiser held at minimum frequency. |
| 3 | SYNLK | 32 to 262 µs: synthesiser locks and receiver calibration begins. |
| 4 | RXLK | 262 to 326 µs: receiver tracks incoming data. |
| 5 | SETTLE | 326 to 358 µs: data still held off. |
| 6 | READY | From 358 µs on. |

Global transitions:
- RESET goes to BIAS, or to PARK when inhibited.
- PARK goes to BIAS once the inhibit is gone.
- Any timed state goes to PARK when inhibited.
- BIAS goes to SYNLK, then RXLK, then SETTLE, then READY, each at its threshold.

Lane states:
- WAIT: the global machine is not in READY.
- LIVE: the lane's data is enabled.
- IDLE: lock-to-reference is low.
- RELOCK: a timed 2 µs window.

Lane transitions:
- WAIT goes to LIVE or to IDLE.
- LIVE goes to IDLE.
- IDLE goes to RELOCK.
- RELOCK goes to LIVE, or back to IDLE.
- Any lane state goes to WAIT when the global machine leaves READY.

Top module: `xcvr_pwrseq`

## Requirements
- R1: While `pll_bypass` or `lp_req` is high, the global machine enters PARK (code 1) on the next clock edge from any state. The first edge with both low moves it to BIAS with the elapsed time restarted at zero.
- R2: After a start, BIAS (code 2) lasts exactly BIAS_US×REF_MHZ cycles. `syn_hold_min` is high in RESET and BIAS only.
- R3: SYNLK (code 3) covers elapsed cycles up to SYN_US×REF_MHZ. `rx_cal_en` is high in codes 3 to 6 only.
- R4: RXLK (code 4) covers elapsed cycles up to RXL_US×REF_MHZ. In WAIT, a lane's `ch_track_en` equals its `lockref_n` while the global code is 4, 5 or 6, and is low otherwise.
- R5: SETTLE (code 5) lasts until DATA_US×REF_MHZ elapsed cycles, with every `ch_data_en` low. READY (code 6) follows. A lane in WAIT whose `lockref_n` is high raises `ch_data_en` (data output and comma detection) one cycle after READY is entered.
- R6: A lane whose `lockref_n` is low has `ch_data_en` low from the next cycle on. In IDLE both of its enables are low.
- R7: When `lockref_n` returns high on an idle lane, the lane spends RELOCK_US×REF_MHZ cycles in RELOCK, with tracking on and data off. After that, `ch_data_en` is high.
- R8: While `rst_n` is low, `seq_state` is 0 and `syn_hold_min`, `tx_force_low`, `rx_freeze` and `dpll_clear` are all high. The first edge after release leaves RESET.
- R9: `pll_sleep` is high exactly when the machine is in PARK and `lp_req` is high.
- R10: When the global machine leaves READY, every lane returns to WAIT one cycle later, dropping `ch_data_en`. This takes priority over any lane relock or lock-to-reference event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_req | input | 1 | Low-power request, parks the sequencer |
| pll_bypass | input | 1 | PLL bypass, parks the sequencer |
| lockref_n | input | NCH | Per-lane lock-to-reference control; low idles the lane |
| syn_hold_min | output | 1 | Hold synthesiser at minimum frequency |
| rx_cal_en | output | 1 | Enable receiver analog calibration |
| tx_force_low | output | 1 | Force serial output to logic 0 |
| rx_freeze | output | 1 | Hold parallel receive data at its last value |
| dpll_clear | output | 1 | Clear phase selection and digital loop filter |
| pll_sleep | output | 1 | Power down the PLL |
| ch_track_en | output | NCH | Per-lane receive data tracking enable |
| ch_data_en | output | NCH | Per-lane data output and comma detection enable |
| seq_state | output | 3 | Global state code (0 to 6, as listed above) |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a lane's lock-to-reference release and the global machine dropping out of READY on a low-power request. The bench drives both on the same falling clock edge and expects the lane to show one RELOCK cycle and then fall to WAIT, with data never enabled. The second pair is an inhibit landing on the very cycle a phase threshold is reached. Long random runs with rare inhibits and frequent per-lane toggles produce this case. Every cycle, each output is compared against a reference model that derives the state from the elapsed-cycle count.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [2:0] {
        SQ_RESET  = 3'd0,
        SQ_PARK   = 3'd1,
        SQ_BIAS   = 3'd2,
        SQ_SYNLK  = 3'd3,
        SQ_RXLK   = 3'd4,
        SQ_SETTLE = 3'd5,
        SQ_READY  = 3'd6
    } seq_st_e;

    typedef enum logic [1:0] {
        LN_WAIT   = 2'd0,
        LN_LIVE   = 2'd1,
        LN_IDLE   = 2'd2,
        LN_RELOCK = 2'd3
    } lane_st_e;

endpackage

// File: rtl/pwrseq_core.sv
module pwrseq_core
    import pwrseq_pkg::*;
#(
    parameter int unsigned C_BIAS = 4000,
    parameter int unsigned C_SYN  = 32750,
    parameter int unsigned C_RX   = 40750,
    parameter int unsigned C_DATA = 44750
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    lp_req,
    input  logic    pll_bypass,
    output seq_st_e st_o,
    output logic    syn_hold_min,
    output logic    rx_cal_en,
    output logic    track_ok,
    output logic    ready,
    output logic    tx_force_low,
    output logic    rx_freeze,
    output logic    dpll_clear,
    output logic    pll_sleep
);

    localparam int CW = $clog2(C_DATA + 1);
    localparam logic [CW-1:0] END_BIAS = CW'(C_BIAS - 1);
    localparam logic [CW-1:0] END_SYN  = CW'(C_SYN - 1);
    localparam logic [CW-1:0] END_RX   = CW'(C_RX - 1);
    localparam logic [CW-1:0] END_DATA = CW'(C_DATA - 1);

    seq_st_e       st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          inhibit;

    assign inhibit = lp_req | pll_bypass;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= SQ_RESET;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state: elapsed counter runs through all timed phases
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            SQ_RESET: begin
                cnt_d = '0;
                st_d  = inhibit ? SQ_PARK : SQ_BIAS;
            end
            SQ_PARK: begin
                cnt_d = '0;
                if (!inhibit) st_d = SQ_BIAS;
            end
            SQ_BIAS: begin
                if (inhibit) begin
                    st_d = SQ_PARK; cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == END_BIAS) st_d = SQ_SYNLK;
                end
            end
            SQ_SYNLK: begin
                if (inhibit) begin
                    st_d = SQ_PARK; cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == END_SYN) st_d = SQ_RXLK;
                end
            end
            SQ_RXLK: begin
                if (inhibit) begin
                    st_d = SQ_PARK; cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == END_RX) st_d = SQ_SETTLE;
                end
            end
            SQ_SETTLE: begin
                if (inhibit) begin
                    st_d = SQ_PARK; cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == END_DATA) st_d = SQ_READY;
                end
            end
            SQ_READY: begin
                if (inhibit) begin
                    st_d = SQ_PARK; cnt_d = '0;
                end
            end
            default: begin
                st_d  = SQ_RESET;
                cnt_d = '0;
            end
        endcase
    end

    // outputs decoded from the registered state
    always_comb begin
        syn_hold_min = 1'b0;
        rx_cal_en    = 1'b0;
        track_ok     = 1'b0;
        ready        = 1'b0;
        tx_force_low = 1'b0;
        rx_freeze    = 1'b0;
        dpll_clear   = 1'b0;
        pll_sleep    = 1'b0;
        unique case (st_q)
            SQ_RESET: begin
                syn_hold_min = 1'b1;
                tx_force_low = 1'b1;
                rx_freeze    = 1'b1;
                dpll_clear   = 1'b1;
            end
            SQ_PARK:   pll_sleep = lp_req;
            SQ_BIAS:   syn_hold_min = 1'b1;
            SQ_SYNLK:  rx_cal_en = 1'b1;
            SQ_RXLK, SQ_SETTLE: begin
                rx_cal_en = 1'b1;
                track_ok  = 1'b1;
            end
            SQ_READY: begin
                rx_cal_en = 1'b1;
                track_ok  = 1'b1;
                ready     = 1'b1;
            end
            default: ;
        endcase
    end

    assign st_o = st_q;

endmodule

// File: rtl/pwrseq_lane.sv
module pwrseq_lane
    import pwrseq_pkg::*;
#(
    parameter int unsigned C_REL = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic g_track,
    input  logic g_ready,
    input  logic lockref_n,
    output logic track_en,
    output logic data_en
);

    localparam int RW = (C_REL > 1) ? $clog2(C_REL + 1) : 1;
    localparam logic [RW-1:0] END_REL = RW'(C_REL - 1);

    lane_st_e      st_q, st_d;
    logic [RW-1:0] rc_q, rc_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= LN_WAIT;
            rc_q <= '0;
        end else begin
            st_q <= st_d;
            rc_q <= rc_d;
        end
    end

    // loss of global readiness outranks any lane event
    always_comb begin
        st_d = st_q;
        rc_d = rc_q;
        if (!g_ready) begin
            st_d = LN_WAIT;
            rc_d = '0;
        end else begin
            unique case (st_q)
                LN_WAIT:  st_d = lockref_n ? LN_LIVE : LN_IDLE;
                LN_LIVE:  if (!lockref_n) st_d = LN_IDLE;
                LN_IDLE: begin
                    rc_d = '0;
                    if (lockref_n) st_d = LN_RELOCK;
                end
                LN_RELOCK: begin
                    if (!lockref_n) begin
                        st_d = LN_IDLE;
                    end else if (rc_q == END_REL) begin
                        st_d = LN_LIVE;
                    end else begin
                        rc_d = rc_q + 1'b1;
                    end
                end
            endcase
        end
    end

    always_comb begin
        unique case (st_q)
            LN_WAIT:   begin track_en = g_track & lockref_n; data_en = 1'b0; end
            LN_LIVE:   begin track_en = 1'b1;                data_en = 1'b1; end
            LN_IDLE:   begin track_en = 1'b0;                data_en = 1'b0; end
            LN_RELOCK: begin track_en = 1'b1;                data_en = 1'b0; end
        endcase
    end

endmodule

// File: rtl/xcvr_pwrseq.sv
module xcvr_pwrseq
    import pwrseq_pkg::*;
#(
    parameter int unsigned REF_MHZ   = 125,
    parameter int unsigned NCH       = 4,
    parameter int unsigned BIAS_US   = 32,
    parameter int unsigned SYN_US    = 262,
    parameter int unsigned RXL_US    = 326,
    parameter int unsigned DATA_US   = 358,
    parameter int unsigned RELOCK_US = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           lp_req,
    input  logic           pll_bypass,
    input  logic [NCH-1:0] lockref_n,
    output logic           syn_hold_min,
    output logic           rx_cal_en,
    output logic           tx_force_low,
    output logic           rx_freeze,
    output logic           dpll_clear,
    output logic           pll_sleep,
    output logic [NCH-1:0] ch_track_en,
    output logic [NCH-1:0] ch_data_en,
    output logic [2:0]     seq_state
);

    localparam int unsigned C_BIAS = BIAS_US   * REF_MHZ;
    localparam int unsigned C_SYN  = SYN_US    * REF_MHZ;
    localparam int unsigned C_RX   = RXL_US    * REF_MHZ;
    localparam int unsigned C_DATA = DATA_US   * REF_MHZ;
    localparam int unsigned C_REL  = RELOCK_US * REF_MHZ;

    seq_st_e st;
    logic    track_ok;
    logic    ready;

    pwrseq_core #(
        .C_BIAS (C_BIAS),
        .C_SYN  (C_SYN),
        .C_RX   (C_RX),
        .C_DATA (C_DATA)
    ) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .lp_req       (lp_req),
        .pll_bypass   (pll_bypass),
        .st_o         (st),
        .syn_hold_min (syn_hold_min),
        .rx_cal_en    (rx_cal_en),
        .track_ok     (track_ok),
        .ready        (ready),
        .tx_force_low (tx_force_low),
        .rx_freeze    (rx_freeze),
        .dpll_clear   (dpll_clear),
        .pll_sleep    (pll_sleep)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        pwrseq_lane #(.C_REL(C_REL)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .g_track   (track_ok),
            .g_ready   (ready),
            .lockref_n (lockref_n[c]),
            .track_en  (ch_track_en[c]),
            .data_en   (ch_data_en[c])
        );
    end

    assign seq_state = st;

endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk #(
    parameter int unsigned NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           lp_req,
    input logic           pll_bypass,
    input logic [NCH-1:0] lockref_n,
    input logic           syn_hold_min,
    input logic           rx_cal_en,
    input logic           tx_force_low,
    input logic           rx_freeze,
    input logic           dpll_clear,
    input logic           pll_sleep,
    input logic [NCH-1:0] ch_track_en,
    input logic [NCH-1:0] ch_data_en,
    input logic [2:0]     seq_state
);

    a_r1_inhibit_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_req || pll_bypass) |=> seq_state == 3'd1);

    a_r2_bias_holds_min: assert property (@(posedge clk) disable iff (!rst_n)
        seq_state == 3'd2 |-> syn_hold_min && !rx_cal_en);

    a_r3_synlk_after_bias: assert property (@(posedge clk) disable iff (!rst_n)
        seq_state == 3'd3 |-> ($past(seq_state) == 3'd2 || $past(seq_state) == 3'd3));

    a_r4_track_needs_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_track_en) |-> (seq_state >= 3'd4 && seq_state <= 3'd6) || $past(seq_state) == 3'd6);

    a_r5_settle_dark: assert property (@(posedge clk) disable iff (!rst_n)
        seq_state == 3'd5 |-> ch_data_en == '0);

    a_r5_data_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_data_en) |-> $past(seq_state) == 3'd6);

    a_r8_reset_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        seq_state == 3'd0 |-> tx_force_low && rx_freeze && dpll_clear && syn_hold_min);

    a_r9_sleep_only_parked: assert property (@(posedge clk) disable iff (!rst_n)
        pll_sleep |-> seq_state == 3'd1 && lp_req);

    for (genvar i = 0; i < NCH; i++) begin : g_ln
        a_r6_lockref_idles: assert property (@(posedge clk) disable iff (!rst_n)
            !lockref_n[i] |=> !ch_data_en[i]);
    end

endmodule

bind xcvr_pwrseq pwrseq_chk #(.NCH(NCH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lp_req       (lp_req),
    .pll_bypass   (pll_bypass),
    .lockref_n    (lockref_n),
    .syn_hold_min (syn_hold_min),
    .rx_cal_en    (rx_cal_en),
    .tx_force_low (tx_force_low),
    .rx_freeze    (rx_freeze),
    .dpll_clear   (dpll_clear),
    .pll_sleep    (pll_sleep),
    .ch_track_en  (ch_track_en),
    .ch_data_en   (ch_data_en),
    .seq_state    (seq_state)
);

// File: tb/sim_xcvr_pwrseq.sv
module sim_xcvr_pwrseq;

    localparam int CLK_PERIOD = 10;
    localparam int REF = 2;
    localparam int NCH = 4;
    localparam int C_BIAS = 32 * REF;
    localparam int C_SYN  = 262 * REF;
    localparam int C_RX   = 326 * REF;
    localparam int C_DATA = 358 * REF;
    localparam int C_REL  = 2 * REF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lp_req = 1'b0;
    logic pll_bypass = 1'b0;
    logic [NCH-1:0] lockref_n = '1;
    logic syn_hold_min, rx_cal_en, tx_force_low, rx_freeze, dpll_clear, pll_sleep;
    logic [NCH-1:0] ch_track_en, ch_data_en;
    logic [2:0] seq_state;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xcvr_pwrseq #(.REF_MHZ(REF), .NCH(NCH)) u0 (
        .clk, .rst_n, .lp_req, .pll_bypass, .lockref_n,
        .syn_hold_min, .rx_cal_en, .tx_force_low, .rx_freeze, .dpll_clear,
        .pll_sleep, .ch_track_en, .ch_data_en, .seq_state
    );

    // reference model: elapsed cycles since start, lane modes 0 wait 1 live 2 idle 3 relock
    int m_k = 0;
    bit m_rst = 1;
    bit m_park = 0;
    int m_mode [NCH];
    int m_rc [NCH];

    function automatic int phase_of(int k);
        if (k < C_BIAS) return 2;
        if (k < C_SYN)  return 3;
        if (k < C_RX)   return 4;
        if (k < C_DATA) return 5;
        return 6;
    endfunction

    function automatic int exp_state();
        if (m_rst)  return 0;
        if (m_park) return 1;
        return phase_of(m_k);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_rst = 1; m_park = 0; m_k = 0;
            for (int i = 0; i < NCH; i++) begin m_mode[i] = 0; m_rc[i] = 0; end
        end else begin
            bit g_rdy;
            g_rdy = (exp_state() == 6);
            for (int i = 0; i < NCH; i++) begin
                if (!g_rdy) begin
                    m_mode[i] = 0; m_rc[i] = 0;
                end else begin
                    case (m_mode[i])
                        0: m_mode[i] = lockref_n[i] ? 1 : 2;
                        1: if (!lockref_n[i]) m_mode[i] = 2;
                        2: if (lockref_n[i]) begin m_mode[i] = 3; m_rc[i] = 0; end
                        default: begin
                            if (!lockref_n[i]) m_mode[i] = 2;
                            else if (m_rc[i] == C_REL - 1) m_mode[i] = 1;
                            else m_rc[i]++;
                        end
                    endcase
                end
            end
            if (lp_req || pll_bypass) begin
                m_rst = 0; m_park = 1;
            end else if (m_rst || m_park) begin
                m_rst = 0; m_park = 0; m_k = 0;
            end else if (m_k < C_DATA) begin
                m_k++;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string tag_of(int s);
        case (s)
            0: return "R8 state";
            1: return "R1 state";
            2: return "R2 state";
            3: return "R3 state";
            4: return "R4 state";
            default: return "R5 state";
        endcase
    endfunction

    task automatic compare_all();
        int s;
        logic [NCH-1:0] et, ed;
        s = exp_state();
        for (int i = 0; i < NCH; i++) begin
            case (m_mode[i])
                0: et[i] = (s >= 4 && s <= 6) && lockref_n[i];
                1: et[i] = 1'b1;
                2: et[i] = 1'b0;
                default: et[i] = 1'b1;
            endcase
            ed[i] = (m_mode[i] == 1);
        end
        chk(tag_of(s), 32'(seq_state), 32'(s));
        chk("R2 syn_hold_min", 32'(syn_hold_min), 32'(s == 0 || s == 2));
        chk("R3 rx_cal_en", 32'(rx_cal_en), 32'(s >= 3 && s <= 6));
        chk("R8 reset strobes", 32'({tx_force_low, rx_freeze, dpll_clear}), (s == 0) ? 32'h7 : 32'h0);
        chk("R9 pll_sleep", 32'(pll_sleep), 32'(s == 1 && lp_req));
        chk("R4 ch_track_en", 32'(ch_track_en), 32'(et));
        chk("R6 ch_data_en", 32'(ch_data_en), 32'(ed));
    endtask

    task automatic step(int n = 1);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        step(3);
        chk("R8 reset code", 32'(seq_state), 32'd0);
        rst_n = 1'b1;
        step(1);
        chk("R8 leaves reset to BIAS", 32'(seq_state), 32'd2);
        step(C_BIAS - 1);
        chk("R2 last BIAS cycle", 32'(seq_state), 32'd2);
        step(1);
        chk("R3 SYNLK after BIAS", 32'(seq_state), 32'd3);
        step(C_DATA - C_BIAS - 1);
        chk("R5 SETTLE last cycle", 32'(ch_data_en), 32'd0);
        step(1);
        chk("R5 READY entered", 32'(seq_state), 32'd6);
        chk("R5 data not yet", 32'(ch_data_en), 32'd0);
        step(1);
        chk("R5 data one cycle after READY", 32'(ch_data_en), 32'hF);

        // lane 1 idle then relock
        lockref_n[1] = 1'b0;
        step(1);
        chk("R6 idle lane dark", 32'({ch_track_en[1], ch_data_en[1]}), 32'd0);
        step(2);
        lockref_n[1] = 1'b1;
        step(C_REL);
        chk("R7 relock window data off", 32'(ch_data_en[1]), 32'd0);
        chk("R7 relock tracking on", 32'(ch_track_en[1]), 32'd1);
        step(1);
        chk("R7 data back after relock", 32'(ch_data_en[1]), 32'd1);

        // same-cycle: lane 2 release with low-power entry
        lockref_n[2] = 1'b0;
        step(2);
        lockref_n[2] = 1'b1;
        lp_req = 1'b1;
        step(1);
        chk("R1 parked", 32'(seq_state), 32'd1);
        chk("R9 sleep in park", 32'(pll_sleep), 32'd1);
        step(1);
        chk("R10 lanes back to wait", 32'({ch_data_en, ch_track_en}), 32'd0);
        step(5);
        lp_req = 1'b0;
        step(1);
        chk("R1 restart at BIAS", 32'(seq_state), 32'd2);
        step(C_BIAS + 10);
        pll_bypass = 1'b1;
        step(1);
        chk("R9 no sleep on bypass", 32'(pll_sleep), 32'd0);
        pll_bypass = 1'b0;
        step(1);
        chk("R1 bypass restart", 32'(seq_state), 32'd2);

        // random phase
        for (int t = 0; t < 40000; t++) begin
            step(1);
            if (!rst_n) begin
                if ($urandom_range(0, 2) == 0) rst_n = 1'b1;
            end else if ($urandom_range(0, 6999) == 0) begin
                rst_n = 1'b0;
            end
            if ($urandom_range(0, 1499) == 0) lp_req = ~lp_req;
            if (lp_req && $urandom_range(0, 99) == 0) lp_req = 1'b0;
            if ($urandom_range(0, 2999) == 0) pll_bypass = 1'b1;
            else if (pll_bypass && $urandom_range(0, 19) == 0) pll_bypass = 1'b0;
            for (int i = 0; i < NCH; i++)
                if ($urandom_range(0, 39) == 0) lockref_n[i] = ~lockref_n[i];
        end
        step(2);
        finish_run();
    end

endmodule